// File: doc/BRIEF.md
# Group-01 Opcode Bus-Cycle Sequencer

This block is the cycle-by-cycle controller for the regular family of an 8-bit accumulator processor, the family in which the low two opcode bits are 01. It fetches the opcode and then the byte after it. From the opcode it walks one of eight addressing sequences, driving a 16-bit address, a write strobe and write data on every clock. On the final operand cycle it presents the result of a small combinational ALU, together with enables for the accumulator and for the flags. The accumulator, index registers and carry are supplied by the surrounding core. The block keeps the program counter, the instruction register, a zero-page pointer byte and an effective-address register of its own.

The second bus cycle is the same read of the byte after the opcode, whatever the opcode is. Immediate mode simply uses that byte. A store uses the same address walk as the matching load and only turns its final access into a write of the accumulator. As a result, a store with immediate mode (opcode 0x89) ends after two cycles with no write and no register or flag effect. Memory is assumed to answer a read in the same cycle in which the address is driven.

The state machine has eight named states. FETCH reads the opcode at PC. OPND blindly reads PC+1. ZPIDX is a dummy zero-page read while the index is added. ABSHI reads the high address byte. PTRLO and PTRHI read the two pointer bytes from page zero. FIXUP is the extra indexed cycle that stores take. DATA is the operand access. Its transitions are:
- FETCH goes to OPND.
- OPND goes to FETCH for immediate mode and for any opcode outside the family, to DATA for zp, to ZPIDX for zp,X and (zp,X), to ABSHI for the absolute modes, and to PTRLO for (zp),Y.
- ZPIDX goes to DATA for zp,X and to PTRLO for (zp,X).
- ABSHI goes to FIXUP for indexed stores and to DATA otherwise.
- PTRLO goes to PTRHI.
- PTRHI goes to FIXUP for (zp),Y stores and to DATA otherwise.
- FIXUP goes to DATA, and DATA goes to FETCH.

Top module: `g01_seq`

## Requirements
- R1: Only an opcode whose bits 1:0 equal 01 is executed. Any other opcode takes two cycles, the fetch and the blind read, advances PC by one only, and asserts no write, no accumulator enable and no flag enable.
- R2: `sync` is high exactly in the opcode-fetch cycle, which is a read at PC. After reset, the first fetch is at address 0x0200.
- R3: The cycle after every opcode fetch is a read of address PC+1, whatever the opcode.
- R4: Immediate mode (bits 4:2 = 010) takes 2 cycles, uses the byte read in the second cycle as its operand and leaves PC at opcode address + 2.
- R5: zp (001) reads {0x00, b1} in cycle 3 (3 cycles). zp,X (101) reads {0x00, b1} as a dummy and then {0x00, (b1+X) mod 256} (4 cycles). Both leave PC at +2.
- R6: abs (011) reads the high byte at PC+2 and then {b2,b1} (4 cycles). abs,Y (110) and abs,X (111) loads read {b2,b1}+index as a full 16-bit sum in cycle 4. Stores read that address in cycle 4 and write it in cycle 5. All leave PC at +3.
- R7: (zp,X) (000) takes 6 cycles: a dummy read {0x00,b1}, then pointer reads at p=(b1+X) mod 256 and (p+1) mod 256 in page zero, then the operand at the pointer.
- R8: (zp),Y (100) reads the pointer at {0x00,b1} and {0x00,(b1+1) mod 256}, then accesses pointer+Y in cycle 5 for loads. A store reads it in cycle 5 and writes it in cycle 6.
- R9: A store (bits 7:5 = 100) in any mode except immediate asserts `wr` only on its final cycle, with `dout` equal to the accumulator, and asserts no accumulator or flag enable.
- R10: Opcode 0x89 completes in two cycles with no write, no accumulator enable and no flag enable, and leaves PC at +2.
- R11: ORA (000), AND (001), EOR (010) and LDA (101) assert `acc_we` with the result and set N and Z. `flag_we`/`flag_res` bits are 3=N, 2=V, 1=Z, 0=C, so the enable is 1010.
- R12: ADC (011) computes A+M+C and SBC (111) computes A+~M+C in binary. Both assert `acc_we` and write N, V, Z and C (enable 1111).
- R13: CMP (110) computes A-M, writes N, Z and C with C = (A >= M) (enable 1011) and does not assert `acc_we`. Execution outputs are active only in an instruction's final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Read data returned for the current address |
| x_reg | input | 8 | X index register value |
| y_reg | input | 8 | Y index register value |
| acc | input | 8 | Accumulator value |
| carry_in | input | 1 | Current carry flag |
| addr | output | 16 | Bus address for this cycle |
| dout | output | 8 | Write data (accumulator when writing, else zero) |
| wr | output | 1 | 1 = write cycle, 0 = read cycle |
| sync | output | 1 | High during an opcode-fetch cycle |
| acc_we | output | 1 | Accumulator write enable |
| acc_res | output | 8 | ALU result |
| flag_we | output | 4 | Flag enables N,V,Z,C |
| flag_res | output | 4 | Flag values N,V,Z,C |

## Verification
The hardest cases to reach are the wrap-arounds inside page zero. A zp,X sum or a (zp,X) pointer that crosses 0xFF must fold back to 0x00 instead of carrying into the high byte. The (zp),Y pointer high byte must be read from 0x00 when the pointer sits at 0xFF. The stimulus reaches these cases by choosing the second opcode byte and the index values, so that b1+X or b1+1 overflows 8 bits. A full sweep of all 64 operation and mode pairs then compares every bus cycle against an address model computed in the bench. That model includes the extra read cycle for indexed stores and the degenerate store-immediate.

// File: rtl/g01_pkg.sv
package g01_pkg;

    typedef enum logic [2:0] {
        OP_ORA = 3'b000,
        OP_AND = 3'b001,
        OP_EOR = 3'b010,
        OP_ADC = 3'b011,
        OP_STA = 3'b100,
        OP_LDA = 3'b101,
        OP_CMP = 3'b110,
        OP_SBC = 3'b111
    } alu_op_e;

    typedef enum logic [2:0] {
        AM_IZX = 3'b000,
        AM_ZP  = 3'b001,
        AM_IMM = 3'b010,
        AM_ABS = 3'b011,
        AM_IZY = 3'b100,
        AM_ZPX = 3'b101,
        AM_ABY = 3'b110,
        AM_ABX = 3'b111
    } amode_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_OPND,
        S_ZPIDX,
        S_ABSHI,
        S_PTRLO,
        S_PTRHI,
        S_FIXUP,
        S_DATA
    } seq_state_e;

    // bit order: n (3), v (2), z (1), c (0)
    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/g01_decode.sv
module g01_decode
    import g01_pkg::*;
(
    input  logic [7:0] opc,
    output alu_op_e    op,
    output amode_e     mode,
    output logic       in_group,
    output logic       is_store,
    output logic       use_y
);
    always_comb begin
        op       = alu_op_e'(opc[7:5]);
        mode     = amode_e'(opc[4:2]);
        in_group = (opc[1:0] == 2'b01);
        is_store = (opc[7:5] == OP_STA);
        use_y    = (opc[4:2] == AM_ABY) || (opc[4:2] == AM_IZY);
    end
endmodule

// File: rtl/g01_alu.sv
module g01_alu
    import g01_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          acc_we,
    output flags_t        fl,
    output flags_t        fl_we
);
    logic [DW:0]   sum;
    logic [DW-1:0] m_eff;
    logic          c_eff;

    always_comb begin
        m_eff = ((op == OP_SBC) || (op == OP_CMP)) ? ~m : m;
        c_eff = (op == OP_CMP) ? 1'b1 : cin;
        sum   = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, c_eff};
        res    = '0;
        acc_we = 1'b0;
        fl_we  = '0;
        unique case (op)
            OP_ORA: begin res = a | m; acc_we = 1'b1; fl_we = 4'b1010; end
            OP_AND: begin res = a & m; acc_we = 1'b1; fl_we = 4'b1010; end
            OP_EOR: begin res = a ^ m; acc_we = 1'b1; fl_we = 4'b1010; end
            OP_LDA: begin res = m;     acc_we = 1'b1; fl_we = 4'b1010; end
            OP_ADC, OP_SBC: begin
                res = sum[DW-1:0]; acc_we = 1'b1; fl_we = 4'b1111;
            end
            OP_CMP: begin res = sum[DW-1:0]; fl_we = 4'b1011; end
            OP_STA: begin res = a; end
            default: begin res = '0; end
        endcase
        fl.n = res[DW-1];
        fl.v = (a[DW-1] == m_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
        fl.z = (res == '0);
        fl.c = sum[DW];
    end
endmodule

// File: rtl/g01_seq.sv
module g01_seq
    import g01_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int unsigned RESET_PC = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     din,
    input  logic [DW-1:0]     x_reg,
    input  logic [DW-1:0]     y_reg,
    input  logic [DW-1:0]     acc,
    input  logic              carry_in,
    output logic [2*DW-1:0]   addr,
    output logic [DW-1:0]     dout,
    output logic              wr,
    output logic              sync,
    output logic              acc_we,
    output logic [DW-1:0]     acc_res,
    output logic [3:0]        flag_we,
    output logic [3:0]        flag_res
);
    localparam int AW = 2 * DW;

    seq_state_e    state, nstate;
    logic [AW-1:0] pc;
    logic [DW-1:0] ir;
    logic [DW-1:0] ptr;
    logic [AW-1:0] ea;

    alu_op_e op;
    amode_e  mode;
    logic    grp, st, use_y;

    g01_decode u_dec (
        .opc      (ir),
        .op       (op),
        .mode     (mode),
        .in_group (grp),
        .is_store (st),
        .use_y    (use_y)
    );

    logic [DW-1:0] idx;
    logic [DW-1:0] ptr_idx;
    logic [AW-1:0] hi_lo;
    logic [AW-1:0] zp_ptr;

    always_comb begin
        idx     = use_y ? y_reg : x_reg;
        ptr_idx = ptr + idx;
        hi_lo   = {din, ea[DW-1:0]};
        zp_ptr  = {{DW{1'b0}}, ptr};
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_FETCH: nstate = S_OPND;
            S_OPND: begin
                if (!grp) begin
                    nstate = S_FETCH;
                end else begin
                    unique case (mode)
                        AM_IMM:                 nstate = S_FETCH;
                        AM_ZP:                  nstate = S_DATA;
                        AM_ZPX, AM_IZX:         nstate = S_ZPIDX;
                        AM_ABS, AM_ABX, AM_ABY: nstate = S_ABSHI;
                        AM_IZY:                 nstate = S_PTRLO;
                        default:                nstate = S_FETCH;
                    endcase
                end
            end
            S_ZPIDX: nstate = (mode == AM_ZPX) ? S_DATA : S_PTRLO;
            S_ABSHI: nstate = ((mode != AM_ABS) && st) ? S_FIXUP : S_DATA;
            S_PTRLO: nstate = S_PTRHI;
            S_PTRHI: nstate = ((mode == AM_IZY) && st) ? S_FIXUP : S_DATA;
            S_FIXUP: nstate = S_DATA;
            S_DATA:  nstate = S_FETCH;
            default: nstate = S_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= nstate;
    end

    // address and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= AW'(RESET_PC);
            ir  <= '0;
            ptr <= '0;
            ea  <= '0;
        end else begin
            unique case (state)
                S_FETCH: begin
                    ir <= din;
                    pc <= pc + 1'b1;
                end
                S_OPND: begin
                    if (grp) begin
                        pc <= pc + 1'b1;
                        unique case (mode)
                            AM_ZP:                  ea <= {{DW{1'b0}}, din};
                            AM_ZPX, AM_IZX, AM_IZY: ptr <= din;
                            AM_ABS, AM_ABX, AM_ABY: ea[DW-1:0] <= din;
                            default: ;
                        endcase
                    end
                end
                S_ZPIDX: begin
                    if (mode == AM_ZPX) ea <= {{DW{1'b0}}, ptr_idx};
                    else                ptr <= ptr_idx;
                end
                S_ABSHI: begin
                    pc <= pc + 1'b1;
                    ea <= (mode == AM_ABS) ? hi_lo : hi_lo + {{DW{1'b0}}, idx};
                end
                S_PTRLO: begin
                    ea[DW-1:0] <= din;
                    ptr        <= ptr + 1'b1;
                end
                S_PTRHI: begin
                    ea <= (mode == AM_IZY) ? hi_lo + {{DW{1'b0}}, idx} : hi_lo;
                end
                default: ;
            endcase
        end
    end

    // outputs
    logic          exec_now;
    logic [DW-1:0] alu_res;
    logic          alu_we;
    flags_t        alu_fl, alu_fwe;

    g01_alu #(.DW(DW)) u_alu (
        .op     (op),
        .a      (acc),
        .m      (din),
        .cin    (carry_in),
        .res    (alu_res),
        .acc_we (alu_we),
        .fl     (alu_fl),
        .fl_we  (alu_fwe)
    );

    always_comb begin
        unique case (state)
            S_FETCH, S_OPND, S_ABSHI:   addr = pc;
            S_ZPIDX, S_PTRLO, S_PTRHI:  addr = zp_ptr;
            S_FIXUP, S_DATA:            addr = ea;
            default:                    addr = pc;
        endcase
        sync     = (state == S_FETCH);
        wr       = (state == S_DATA) && st;
        dout     = wr ? acc : '0;
        exec_now = grp && !st &&
                   (((state == S_OPND) && (mode == AM_IMM)) || (state == S_DATA));
        acc_we   = exec_now && alu_we;
        acc_res  = alu_res;
        flag_we  = exec_now ? alu_fwe : 4'b0000;
        flag_res = alu_fl;
    end
endmodule

// File: rtl/g01_seq_chk.sv
module g01_seq_chk #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync,
    input logic          wr,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic [DW-1:0] acc,
    input logic          acc_we,
    input logic [3:0]    flag_we
);
    AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> !wr); // R2

    AST_BLIND_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (!wr && !sync && addr == $past(addr) + 1'b1)); // R3

    AST_STORE_IMM_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && din == 8'h89) |=> (!wr && !acc_we && flag_we == 4'b0000) ##1 sync); // R10

    AST_OTHER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && din[1:0] != 2'b01) |=> (!acc_we && flag_we == 4'b0000 && !wr) ##1 sync); // R1

    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (dout == acc && !sync)); // R9

    AST_STORE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (!acc_we && flag_we == 4'b0000)); // R9

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we == 4'b0000 || flag_we == 4'b1010 ||
         flag_we == 4'b1111 || flag_we == 4'b1011)); // R11
endmodule

bind g01_seq g01_seq_chk #(.DW(DW), .AW(2 * DW)) u_g01_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync    (sync),
    .wr      (wr),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .acc     (acc),
    .acc_we  (acc_we),
    .flag_we (flag_we)
);

// File: tb/g01_seq_bench.sv
`timescale 1ns/1ps
module g01_seq_bench;
    localparam logic [15:0] PC0 = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din, xr = 8'h0, yr = 8'h0, ar = 8'h0;
    logic        cin = 1'b0;
    logic [15:0] addr;
    logic [7:0]  dout, acc_res;
    logic        wr, sync, acc_we;
    logic [3:0]  flag_we, flag_res;
    logic [7:0]  p_op = 8'hEA, p_b1 = 8'h00, p_b2 = 8'h00;

    int checks = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    g01_seq u_g01_seq (
        .clk(clk), .rst_n(rst_n), .din(din), .x_reg(xr), .y_reg(yr),
        .acc(ar), .carry_in(cin), .addr(addr), .dout(dout), .wr(wr),
        .sync(sync), .acc_we(acc_we), .acc_res(acc_res),
        .flag_we(flag_we), .flag_res(flag_res)
    );

    function automatic logic [7:0] memf(input logic [15:0] a, input logic [7:0] o,
                                        input logic [7:0] b1, input logic [7:0] b2);
        if (a == PC0)              return o;
        if (a == PC0 + 16'd1)      return b1;
        if (a == PC0 + 16'd2)      return b2;
        return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h3C;
    endfunction

    always_comb din = memf(addr, p_op, p_b1, p_b2);

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // expected execution result from the requirement text
    task automatic ref_exec(input logic [2:0] aaa, input logic [7:0] a, input logic [7:0] m,
                            input logic c, output logic [7:0] r, output logic we,
                            output logic [3:0] fwe, output logic [3:0] fv, output string rq);
        logic [8:0] s;
        logic v;
        s = 9'd0; v = 1'b0; r = 8'd0; we = 1'b0; fwe = 4'b0000; rq = "R11";
        case (aaa)
            3'd0: begin r = a | m; we = 1; fwe = 4'b1010; end
            3'd1: begin r = a & m; we = 1; fwe = 4'b1010; end
            3'd2: begin r = a ^ m; we = 1; fwe = 4'b1010; end
            3'd5: begin r = m;     we = 1; fwe = 4'b1010; end
            3'd3: begin s = {1'b0,a} + {1'b0,m} + {8'd0,c}; r = s[7:0]; we = 1; fwe = 4'b1111;
                        v = (a[7] == m[7]) && (r[7] != a[7]); rq = "R12"; end
            3'd7: begin s = {1'b0,a} + {1'b0,~m} + {8'd0,c}; r = s[7:0]; we = 1; fwe = 4'b1111;
                        v = (a[7] != m[7]) && (r[7] != a[7]); rq = "R12"; end
            3'd6: begin s = {1'b0,a} + {1'b0,~m} + 9'd1; r = s[7:0]; fwe = 4'b1011; rq = "R13"; end
            default: begin rq = "R9"; end
        endcase
        fv = {r[7], v, (r == 8'd0), s[8]};
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [7:0] b1, input logic [7:0] b2,
                          input logic [7:0] av, input logic [7:0] xv, input logic [7:0] yv,
                          input logic c);
        logic [15:0] ea_l[8];
        logic        wr_l[8];
        logic [15:0] ea, npc;
        logic [7:0]  p, idx, m, r;
        logic [2:0]  aaa, bbb;
        logic        st, grp, we, last_wr;
        logic [3:0]  fwe, fv;
        int          n;
        string       rq, xrq;
        aaa = opc[7:5]; bbb = opc[4:2]; st = (aaa == 3'd4); grp = (opc[1:0] == 2'b01);
        for (int i = 0; i < 8; i++) begin ea_l[i] = 16'h0; wr_l[i] = 1'b0; end
        ea_l[0] = PC0; ea_l[1] = PC0 + 16'd1;
        ea = 16'h0; n = 2; npc = PC0 + 16'd2; rq = "R4";
        idx = (bbb == 3'd6 || bbb == 3'd4) ? yv : xv;
        if (!grp) begin
            npc = PC0 + 16'd1; rq = "R1";
        end else begin
            case (bbb)
                3'd2: begin rq = (st) ? "R10" : "R4"; end
                3'd1: begin ea = {8'h00, b1}; ea_l[2] = ea; n = 3; rq = "R5"; end
                3'd5: begin p = b1 + xv; ea = {8'h00, p}; ea_l[2] = {8'h00, b1};
                            ea_l[3] = ea; n = 4; rq = "R5"; end
                3'd3: begin ea = {b2, b1}; ea_l[2] = PC0 + 16'd2; ea_l[3] = ea; n = 4;
                            npc = PC0 + 16'd3; rq = "R6"; end
                3'd6, 3'd7: begin
                    ea = {b2, b1} + {8'h00, idx}; ea_l[2] = PC0 + 16'd2; ea_l[3] = ea;
                    n = st ? 5 : 4; ea_l[4] = ea; npc = PC0 + 16'd3; rq = "R6"; end
                3'd0: begin
                    p = b1 + xv; ea_l[2] = {8'h00, b1}; ea_l[3] = {8'h00, p};
                    ea_l[4] = {8'h00, p + 8'd1};
                    ea = {memf(ea_l[4], opc, b1, b2), memf(ea_l[3], opc, b1, b2)};
                    ea_l[5] = ea; n = 6; rq = "R7"; end
                default: begin
                    ea_l[2] = {8'h00, b1}; ea_l[3] = {8'h00, b1 + 8'd1};
                    ea = {memf(ea_l[3], opc, b1, b2), memf(ea_l[2], opc, b1, b2)} + {8'h00, yv};
                    ea_l[4] = ea; ea_l[5] = ea; n = st ? 6 : 5; rq = "R8"; end
            endcase
        end
        last_wr = grp && st && (bbb != 3'd2);
        wr_l[n-1] = last_wr;
        m = (bbb == 3'd2) ? b1 : memf(ea, opc, b1, b2);
        ref_exec(aaa, av, m, c, r, we, fwe, fv, xrq);
        if (!grp || (st && bbb == 3'd2)) begin we = 1'b0; fwe = 4'b0000; xrq = rq; end

        @(negedge clk);
        rst_n = 1'b0;
        p_op = opc; p_b1 = b1; p_b2 = b2; ar = av; xr = xv; yr = yv; cin = c;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            chk(k < 2 ? "R3" : rq, $sformatf("op %02h cycle %0d addr", opc, k), addr, ea_l[k]);
            chk(wr_l[k] ? "R9" : rq, $sformatf("op %02h cycle %0d wr", opc, k), wr, wr_l[k]);
            if (k == 0) chk("R2", $sformatf("op %02h sync", opc), sync, 1'b1);
            if (wr_l[k]) chk("R9", $sformatf("op %02h store data", opc), dout, av);
            if (k == n - 1) begin
                chk(xrq, $sformatf("op %02h acc_we", opc), acc_we, we);
                chk(xrq, $sformatf("op %02h flag_we", opc), flag_we, fwe);
                if (we) chk(xrq, $sformatf("op %02h result", opc), acc_res, r);
                if (fwe != 4'b0000)
                    chk(xrq, $sformatf("op %02h flags", opc), flag_res & fwe, fv & fwe);
            end else begin
                chk("R13", $sformatf("op %02h cycle %0d early exec", opc, k),
                    {acc_we, flag_we}, 5'b0);
            end
        end
        @(negedge clk);
        chk(rq, $sformatf("op %02h next fetch sync", opc), sync, 1'b1);
        chk(rq, $sformatf("op %02h next pc", opc), addr, npc);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2", "reset addr", addr, PC0);
        chk("R2", "reset sync", sync, 1'b1);
        chk("R2", "reset wr", wr, 1'b0);
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 8; o++)
            for (int md = 0; md < 8; md++)
                run_op({o[2:0], md[2:0], 2'b01}, 8'h44, 8'h31, 8'h9A, 8'h05, 8'h07, 1'b1);
    endtask

    task automatic t_wraps();
        run_op(8'hB5, 8'hF8, 8'h00, 8'h00, 8'h10, 8'h00, 1'b0); // R5 zp,X wrap
        run_op(8'h95, 8'hFF, 8'h00, 8'h5A, 8'h02, 8'h00, 1'b0); // R5 store zp,X wrap
        run_op(8'hA1, 8'hFE, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0); // R7 pointer at FF/00
        run_op(8'h81, 8'hF0, 8'h00, 8'h77, 8'h20, 8'h00, 1'b0); // R7 store
        run_op(8'hB1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hC0, 1'b0); // R8 pointer hi at 00
        run_op(8'h91, 8'hFF, 8'h00, 8'h3E, 8'h00, 8'hF0, 1'b0); // R8 store
        run_op(8'hBD, 8'hF0, 8'h12, 8'h00, 8'h20, 8'h00, 1'b0); // R6 page cross
        run_op(8'h99, 8'hFF, 8'h12, 8'hA5, 8'h00, 8'h01, 1'b0); // R6 store abs,Y
    endtask

    task automatic t_arith();
        run_op(8'h69, 8'h50, 8'h00, 8'h50, 8'h0, 8'h0, 1'b0); // R12 overflow
        run_op(8'h69, 8'h01, 8'h00, 8'hFF, 8'h0, 8'h0, 1'b0); // R12 carry and zero
        run_op(8'hE9, 8'h01, 8'h00, 8'h00, 8'h0, 8'h0, 1'b1); // R12 borrow
        run_op(8'hE9, 8'h7F, 8'h00, 8'h80, 8'h0, 8'h0, 1'b1); // R12 overflow on subtract
        run_op(8'hC9, 8'h42, 8'h00, 8'h42, 8'h0, 8'h0, 1'b0); // R13 equal
        run_op(8'hC9, 8'h43, 8'h00, 8'h42, 8'h0, 8'h0, 1'b1); // R13 less
        run_op(8'h29, 8'h0F, 8'h00, 8'hF0, 8'h0, 8'h0, 1'b0); // R11 zero result
        run_op(8'hA9, 8'h80, 8'h00, 8'h00, 8'h0, 8'h0, 1'b0); // R11 negative
    endtask

    task automatic t_store_imm();
        run_op(8'h89, 8'h12, 8'h34, 8'hCC, 8'h0, 8'h0, 1'b1); // R10
    endtask

    task automatic t_other_groups();
        run_op(8'hA8, 8'h11, 8'h22, 8'h01, 8'h0, 8'h0, 1'b0); // R1 cc=00
        run_op(8'hAA, 8'h11, 8'h22, 8'h01, 8'h0, 8'h0, 1'b0); // R1 cc=10
        run_op(8'h8B, 8'h11, 8'h22, 8'h01, 8'h0, 8'h0, 1'b0); // R1 cc=11
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errs++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        t_reset();
        t_store_imm();
        t_other_groups();
        t_arith();
        t_wraps();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule